// File: doc/BRIEF.md
# Dual-Edge Frame Timestamp Capture

This block stamps frame events (one receive strobe, one transmit strobe) against a free-running reference cycle count. A wide counter advances on every rising edge of the reference clock, and a narrow 4-bit counter advances on every falling edge. Each event is sampled on both edges. The two captured values are merged into one 32-bit raw word. Software can compare the low bits of the two fields to tell whether the event arrived during the high or the low half of a reference cycle. At a 125 MHz reference, one count of the wide field is 8 ns.

A receive capture is presented at once on a pulse-qualified output, together with a decoded half-cycle flag. A transmit capture is stored with a 16-bit frame identifier in a small first-word-fall-through queue. The queue head is visible through two 32-bit register images: the raw word, and an identifier word. A pop strobe stands for the read of the identifier word and retires the head. The queue reports empty and full, and it keeps a sticky overflow flag for captures that had to be discarded.

Top module: `ts_capture_unit`

## Requirements
- R1: While rst_ni is low, and after release until the first capture, ts_empty_o=1, ts_full_o=0, ts_ovf_o=0, rx_vld_o=0 and rx_ahead_o=0. Both reference counters restart from zero.
- R2: The wide counter adds one on every rising clock edge, and the 4-bit counter adds one on every falling edge. In a raw word, bits 27:0 hold the wide count just before the first rising edge that sees the event high after it was low. Bits 31:28 hold the 4-bit count just before the first falling edge that sees the event high after it was low.
- R3: rx_ahead_o is high, together with rx_vld_o, exactly when (bits 3:0 minus bits 31:28) modulo 16 equals 1, which means a difference of 1 or -15. This is the case when the event rose during the high phase of the clock. rx_ahead_o is low at every other time.
- R4: If P is the rising edge that captures a receive event, rx_vld_o is high for exactly one cycle, the cycle after edge P+1, and rx_ts_o carries the raw word in that cycle.
- R5: A transmit event captured at edge P is written into the queue at edge P+2. ts_empty_o and ts_full_o give the occupancy after each edge. The queue depth is FIFO_DEPTH.
- R6: ts_raw_o is the raw word of the head entry. ts_id_o carries the frame identifier, as sampled from tx_fid_i on the write edge, in bits 20:5, and its other bits are zero.
- R7: ts_pop_i high on a rising edge removes the head entry. A pop while the queue is empty is ignored. Nothing else removes an entry.
- R8: A write that arrives while the queue is full, with no pop on the same edge, is discarded. The stored entries stay unchanged, and ts_ovf_o goes high and stays high until reset.
- R9: A write and a pop on the same edge while the queue is full both take effect. The queue stays full and ts_ovf_o is not set.
- R10: Entries leave in the order they were written. The head stays unchanged while no pop occurs.
- R11: An event held high for several cycles produces exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; both edges used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 1 | Receive frame event strobe |
| tx_evt_i | input | 1 | Transmit frame event strobe |
| tx_fid_i | input | 16 | Transmit frame identifier, held until the entry is written |
| rx_ts_o | output | 32 | Raw receive timestamp word |
| rx_vld_o | output | 1 | Single-cycle qualifier for rx_ts_o |
| rx_ahead_o | output | 1 | Receive event arrived in the high clock phase |
| ts_pop_i | input | 1 | Identifier-register read strobe; pops head |
| ts_raw_o | output | 32 | Head entry raw timestamp word |
| ts_id_o | output | 32 | Head entry identifier word, id in bits 20:5 |
| ts_empty_o | output | 1 | Queue holds no entry |
| ts_full_o | output | 1 | Queue holds FIFO_DEPTH entries |
| ts_ovf_o | output | 1 | Sticky: a transmit capture was discarded |

## Verification
The bench drives events both just after a falling edge and a quarter cycle after a rising edge. This separates the two sampling phases. It also lands one high-phase event on a cycle whose wide count ends in zero, so the -15 wrap of the half-cycle test is exercised; a design that compared without modulo arithmetic would clear the flag there. The bench fills the queue to depth and then pushes and pops on the same edge, which catches a design that treats full as a hard block. A further push at full must raise the sticky flag without disturbing the head. A long-held event and a pop on an empty queue are aimed at duplicate captures and at pointer corruption.

// File: rtl/ts_capture_pkg.sv
package ts_capture_pkg;
  localparam int RISE_W  = 28;
  localparam int FALL_W  = 4;
  localparam int FID_W   = 16;
  localparam int FID_LSB = 5;
  localparam int REG_W   = 32;
  localparam int N_CH    = 2;
  localparam int CH_RX   = 0;
  localparam int CH_TX   = 1;

  typedef struct packed {
    logic [FALL_W-1:0] fall;
    logic [RISE_W-1:0] rise;
  } raw_ts_t;

  typedef struct packed {
    raw_ts_t           ts;
    logic [FID_W-1:0]  fid;
  } tx_entry_t;

  // modulo-2^FALL_W difference of 1 covers both +1 and the wrapped -15
  function automatic logic is_ahead(raw_ts_t t);
    logic [FALL_W-1:0] d;
    d = t.rise[FALL_W-1:0] - t.fall;
    return d == FALL_W'(1);
  endfunction
endpackage

// File: rtl/ts_edge_counters.sv
module ts_edge_counters
  import ts_capture_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [RISE_W-1:0] rise_cnt_o,
  output logic [FALL_W-1:0] fall_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_cnt_o <= '0;
    else         rise_cnt_o <= rise_cnt_o + RISE_W'(1);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_cnt_o <= '0;
    else         fall_cnt_o <= fall_cnt_o + FALL_W'(1);
  end
endmodule

// File: rtl/ts_event_capture.sv
module ts_event_capture
  import ts_capture_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [RISE_W-1:0] rise_cnt_i,
  input  logic [FALL_W-1:0] fall_cnt_i,
  output raw_ts_t           ts_o,
  output logic              vld_o
);
  logic              evt_n_q, evt_p_q, hit_q;
  logic              hit;
  logic [FALL_W-1:0] fall_cap_q;
  logic [RISE_W-1:0] rise_cap_q;

  // falling-edge sampler
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_n_q    <= 1'b0;
      fall_cap_q <= '0;
    end else begin
      evt_n_q <= evt_i;
      if (evt_i && !evt_n_q) fall_cap_q <= fall_cnt_i;
    end
  end

  assign hit = evt_i & ~evt_p_q;

  // rising-edge sampler; word assembled one edge later so the falling
  // capture that follows a rising capture is already settled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_p_q    <= 1'b0;
      hit_q      <= 1'b0;
      rise_cap_q <= '0;
      vld_o      <= 1'b0;
      ts_o       <= '0;
    end else begin
      evt_p_q <= evt_i;
      hit_q   <= hit;
      vld_o   <= hit_q;
      if (hit)   rise_cap_q <= rise_cnt_i;
      if (hit_q) ts_o       <= {fall_cap_q, rise_cap_q};
    end
  end
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok, drop;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign pop_ok  = pop_i & ~empty_o;
  assign push_ok = push_i & (~full_o | pop_ok);
  assign drop    = push_i & full_o & ~pop_ok;
  assign data_o  = mem[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && wr_ptr == AW'(g)) mem[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (drop) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_capture_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_evt_i,
  input  logic             tx_evt_i,
  input  logic [FID_W-1:0] tx_fid_i,
  output logic [REG_W-1:0] rx_ts_o,
  output logic             rx_vld_o,
  output logic             rx_ahead_o,
  input  logic             ts_pop_i,
  output logic [REG_W-1:0] ts_raw_o,
  output logic [REG_W-1:0] ts_id_o,
  output logic             ts_empty_o,
  output logic             ts_full_o,
  output logic             ts_ovf_o
);
  localparam int ENTRY_W = $bits(tx_entry_t);

  logic [RISE_W-1:0] rise_cnt;
  logic [FALL_W-1:0] fall_cnt;
  logic [N_CH-1:0]   evt_vec;
  logic [N_CH-1:0]   vld_vec;
  raw_ts_t           ts_vec [N_CH];
  tx_entry_t         wr_entry, head;
  logic [ENTRY_W-1:0] head_bits;

  ts_edge_counters u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_cnt_o (rise_cnt),
    .fall_cnt_o (fall_cnt)
  );

  assign evt_vec[CH_RX] = rx_evt_i;
  assign evt_vec[CH_TX] = tx_evt_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ts_event_capture u_cap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_vec[ch]),
      .rise_cnt_i (rise_cnt),
      .fall_cnt_i (fall_cnt),
      .ts_o       (ts_vec[ch]),
      .vld_o      (vld_vec[ch])
    );
  end

  assign rx_ts_o    = ts_vec[CH_RX];
  assign rx_vld_o   = vld_vec[CH_RX];
  assign rx_ahead_o = vld_vec[CH_RX] & is_ahead(ts_vec[CH_RX]);

  assign wr_entry = '{ts: ts_vec[CH_TX], fid: tx_fid_i};

  ts_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (ENTRY_W)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (vld_vec[CH_TX]),
    .data_i  (wr_entry),
    .pop_i   (ts_pop_i),
    .data_o  (head_bits),
    .empty_o (ts_empty_o),
    .full_o  (ts_full_o),
    .ovf_o   (ts_ovf_o)
  );

  assign head     = tx_entry_t'(head_bits);
  assign ts_raw_o = head.ts;

  always_comb begin
    ts_id_o = '0;
    ts_id_o[FID_LSB +: FID_W] = head.fid;
  end
endmodule

// File: rtl/ts_capture_unit_chk.sv
module ts_capture_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_evt_i,
  input logic        rx_vld_o,
  input logic        rx_ahead_o,
  input logic        ts_pop_i,
  input logic [31:0] ts_raw_o,
  input logic [31:0] ts_id_o,
  input logic        ts_empty_o,
  input logic        ts_full_o,
  input logic        ts_ovf_o
);
  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ts_empty_o && ts_full_o));

  p_rx_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |=> !rx_vld_o);

  p_rx_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> $past(rx_evt_i, 2));

  p_ahead_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ahead_o |-> rx_vld_o);

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_ovf_o |=> ts_ovf_o);

  p_ovf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ts_ovf_o) |-> $past(ts_full_o));

  p_head_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_empty_o && !ts_pop_i) |=>
      (ts_raw_o == $past(ts_raw_o)) && (ts_id_o == $past(ts_id_o)));

  p_id_pad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_empty_o |-> (ts_id_o[31:21] == '0) && (ts_id_o[4:0] == '0));
endmodule

bind ts_capture_unit ts_capture_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_evt_i   (rx_evt_i),
  .rx_vld_o   (rx_vld_o),
  .rx_ahead_o (rx_ahead_o),
  .ts_pop_i   (ts_pop_i),
  .ts_raw_o   (ts_raw_o),
  .ts_id_o    (ts_id_o),
  .ts_empty_o (ts_empty_o),
  .ts_full_o  (ts_full_o),
  .ts_ovf_o   (ts_ovf_o)
);

// File: tb/ts_capture_unit_test.sv
module ts_capture_unit_test;
  localparam int T     = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_evt, tx_evt, ts_pop;
  logic [15:0] tx_fid;
  logic [31:0] rx_ts, ts_raw, ts_id;
  logic        rx_vld, rx_ahead, ts_empty, ts_full, ts_ovf;

  always #(T/2) clk = ~clk;

  ts_capture_unit #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
    .tx_fid_i(tx_fid), .rx_ts_o(rx_ts), .rx_vld_o(rx_vld), .rx_ahead_o(rx_ahead),
    .ts_pop_i(ts_pop), .ts_raw_o(ts_raw), .ts_id_o(ts_id), .ts_empty_o(ts_empty),
    .ts_full_o(ts_full), .ts_ovf_o(ts_ovf)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rx_pulses = 0;
  bit live = 1'b0;

  logic [31:0] rx_at [int];
  bit          rx_ahead_at [int];
  logic [31:0] tx_ts_at [int];
  logic [15:0] tx_fid_at [int];
  bit          pop_at [int];
  logic [31:0] q_ts [$];
  logic [15:0] q_fid [$];
  bit          m_ovf = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model, one step per clock
  always @(negedge clk) if (live) begin
    int n;
    bit do_pop;
    n = cyc;
    do_pop = pop_at.exists(n) && (q_ts.size() > 0);
    if (do_pop) begin
      void'(q_ts.pop_front());
      void'(q_fid.pop_front());
    end
    if (tx_ts_at.exists(n)) begin
      if (q_ts.size() == DEPTH) m_ovf = 1'b1;
      else begin
        q_ts.push_back(tx_ts_at[n]);
        q_fid.push_back(tx_fid_at[n]);
      end
    end
    chk("R5 empty", {31'b0, ts_empty}, {31'b0, q_ts.size() == 0});
    chk("R5 full", {31'b0, ts_full}, {31'b0, q_ts.size() == DEPTH});
    chk("R8 ovf", {31'b0, ts_ovf}, {31'b0, m_ovf});
    if (q_ts.size() > 0) begin
      chk("R10 raw head", ts_raw, q_ts[0]);
      chk("R6 id word", ts_id, {11'b0, q_fid[0], 5'b0});
    end
    if (rx_at.exists(n)) begin
      chk("R4 rx_vld", {31'b0, rx_vld}, 32'd1);
      chk("R2 rx word", rx_ts, rx_at[n]);
      chk("R3 ahead", {31'b0, rx_ahead}, {31'b0, rx_ahead_at[n]});
    end else begin
      chk("R4 rx_vld idle", {31'b0, rx_vld}, 32'd0);
      chk("R3 ahead idle", {31'b0, rx_ahead}, 32'd0);
    end
  end

  always @(negedge clk) if (live && rx_vld) rx_pulses++;

  // tasks enter and leave just after a falling edge
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic rx_low(int hold);
    logic [31:0] c;
    c = cyc;
    rx_evt = 1'b1;
    rx_at[cyc + 2] = {c[3:0], c[27:0]};
    rx_ahead_at[cyc + 2] = 1'b0;
    idle(hold);
    rx_evt = 1'b0;
  endtask

  task automatic tx_low(logic [15:0] fid);
    logic [31:0] c;
    c = cyc;
    tx_fid = fid;
    tx_evt = 1'b1;
    tx_ts_at[cyc + 3] = {c[3:0], c[27:0]};
    tx_fid_at[cyc + 3] = fid;
    idle(1);
    tx_evt = 1'b0;
  endtask

  // event raised a quarter cycle after a rising edge (high phase)
  task automatic rx_high(int want_mod);
    logic [31:0] k0, km;
    do begin @(posedge clk); #(T/4); end while (want_mod >= 0 && (cyc % 16) != want_mod);
    k0 = cyc;
    km = k0 - 1;
    rx_evt = 1'b1;
    rx_at[cyc + 2] = {km[3:0], k0[27:0]};
    rx_ahead_at[cyc + 2] = 1'b1;
    @(posedge clk); #(T/4);
    rx_evt = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic tx_high(logic [15:0] fid);
    logic [31:0] k0, km;
    @(posedge clk); #(T/4);
    k0 = cyc;
    km = k0 - 1;
    tx_fid = fid;
    tx_evt = 1'b1;
    tx_ts_at[cyc + 3] = {km[3:0], k0[27:0]};
    tx_fid_at[cyc + 3] = fid;
    @(posedge clk); #(T/4);
    tx_evt = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic pop1();
    ts_pop = 1'b1;
    pop_at[cyc + 1] = 1'b1;
    idle(1);
    ts_pop = 1'b0;
  endtask

  initial begin
    int p0;
    rx_evt = 1'b0; tx_evt = 1'b0; ts_pop = 1'b0; tx_fid = '0;
    idle(3);
    // R1 during reset
    chk("R1 empty in reset", {31'b0, ts_empty}, 32'd1);
    chk("R1 full in reset", {31'b0, ts_full}, 32'd0);
    chk("R1 ovf in reset", {31'b0, ts_ovf}, 32'd0);
    chk("R1 rx_vld in reset", {31'b0, rx_vld}, 32'd0);
    rst_n = 1'b1;
    live = 1'b1;
    idle(2);
    chk("R1 empty after reset", {31'b0, ts_empty}, 32'd1);
    chk("R1 ahead after reset", {31'b0, rx_ahead}, 32'd0);

    // R2 R3 R4: low-phase and high-phase receive events, including the -15 wrap
    rx_low(1); idle(3);
    rx_low(1); idle(5);
    rx_high(-1); idle(3);
    rx_high(0); idle(3);
    rx_high(7); idle(3);
    rx_low(1); idle(3);

    // R11: long-held event captures once
    p0 = rx_pulses;
    rx_low(4); idle(4);
    chk("R11 single capture", rx_pulses - p0, 32'd1);

    // R5 R6 R10: queue order and id layout
    tx_low(16'h1234); idle(3);
    tx_high(16'hbeef); idle(3);
    tx_low(16'h00a5); idle(4);
    pop1(); idle(1);
    pop1(); pop1();
    // R7: pop on empty is ignored
    pop1(); idle(2);
    chk("R7 empty after extra pop", {31'b0, ts_empty}, 32'd1);
    tx_low(16'h7777); idle(4);
    chk("R7 entry after empty pop", ts_id, {11'b0, 16'h7777, 5'b0});
    pop1(); idle(2);

    // fill to depth
    tx_low(16'h0001); idle(2);
    tx_low(16'h0002); idle(2);
    tx_high(16'h0003); idle(2);
    tx_low(16'h0004); idle(4);
    chk("R5 full at depth", {31'b0, ts_full}, 32'd1);

    // R9: write and pop on the same edge while full
    tx_low(16'h0005); idle(1);
    pop1(); idle(3);
    chk("R9 still full", {31'b0, ts_full}, 32'd1);
    chk("R9 no overflow", {31'b0, ts_ovf}, 32'd0);
    chk("R9 head advanced", ts_id, {11'b0, 16'h0002, 5'b0});

    // R8: write while full without pop
    tx_low(16'h0006); idle(4);
    chk("R8 overflow set", {31'b0, ts_ovf}, 32'd1);
    chk("R8 head kept", ts_id, {11'b0, 16'h0002, 5'b0});

    repeat (5) begin pop1(); idle(1); end
    chk("R7 drained", {31'b0, ts_empty}, 32'd1);
    chk("R8 overflow sticky", {31'b0, ts_ovf}, 32'd1);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule